// File: doc/BRIEF.md
# MII Management Interrupt Controller

This block gathers the interrupt events of an Ethernet controller's MII management logic and folds them into one interrupt line. It watches four sources: completion of a management read or write started by the host, completion of a management frame generated internally (for example by PHY auto-polling), a mismatch reported by an auto-poll comparison, and any change of the PHY-detect status level. Each source has a sticky status flag and an enable flag. The interrupt line is high while any flag is set together with its enable.

Software uses an 8-bit register port. A write loads all enables and clears the status flags written with 1. A read strobe captures the current flags onto the read bus. A hard reset clears everything. A soft reset and a stop request have no effect on the flags, so events are not lost while the rest of the controller is being restarted.

Top module: `mii_irq_ctrl`

## Requirements
- R1: A pulse on `hostCmdDone` sets the host-completion status flag at register bit 1. No other source sets it.
- R2: A pulse on `intCmdDone` sets the internal-completion status flag at register bit 3, whatever the comparison result. It never touches bit 1.
- R3: A pulse on `pollMismatch` sets the auto-poll mismatch status flag at register bit 5. It raises the interrupt only while its enable at bit 4 is set.
- R4: Every change of `phyDetect`, rising or falling, sets the PHY-detect status flag at register bit 7. A level that is held steady through hard reset and after it sets nothing.
- R5: Status flags (odd bits 1, 3, 5, 7) are write-one-to-clear. Writing 0 to a status bit leaves it unchanged.
- R6: Every register write loads the four enables from the even bits 0, 2, 4 and 6. Each enable sits just below its own status bit.
- R7: When a set event and a write-one-to-clear reach the same status flag in the same cycle, the flag ends up set.
- R8: `irqOut` is registered. In each cycle it equals the OR over sources of (status AND enable) as held in the previous cycle.
- R9: While `hardRstN` is low at a clock edge, all status and enable flags, `irqOut` and `regRdData` are cleared.
- R10: `softRst` and `stopReq` leave every status and enable flag unchanged.
- R11: A cycle with `regRdEn` high loads `regRdData` with the register contents of that cycle, visible after the edge. Without the strobe, `regRdData` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hardRstN | input | 1 | Synchronous hard reset, active low |
| softRst | input | 1 | Soft reset request, has no effect on the flags |
| stopReq | input | 1 | Stop request, has no effect on the flags |
| hostCmdDone | input | 1 | Single-cycle pulse: a host-started management access finished |
| intCmdDone | input | 1 | Single-cycle pulse: an internally generated management frame finished |
| pollMismatch | input | 1 | Single-cycle pulse: an auto-poll comparison mismatched |
| phyDetect | input | 1 | PHY-detect status level |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Write data: enables on even bits, clear mask on odd bits |
| regRdEn | input | 1 | Register read strobe |
| regRdData | output | 8 | Captured register contents |
| irqOut | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default of four sources, so the register is 8 bits wide. At that width every flag/enable pair and both halves of the interleaved layout can be reached by random write data, and reads made every other cycle on average show each status flag soon after it changes. Directed cases cover the set-versus-clear collision, both PHY edge directions and a PHY level held high through reset.

// File: rtl/mii_irq_pkg.sv
package mii_irq_pkg;
  localparam int SRC_CNT = 4;
  localparam int REG_W = 2 * SRC_CNT;

  // source index; register bit of status = 2*idx+1, enable = 2*idx
  localparam int SRC_HOST = 0;
  localparam int SRC_INT  = 1;
  localparam int SRC_POLL = 2;
  localparam int SRC_PHY  = 3;

  typedef struct packed {
    logic [SRC_CNT-1:0] setEv;
    logic [SRC_CNT-1:0] clrMask;
    logic               enLoad;
    logic [SRC_CNT-1:0] enData;
    logic               rdCapture;
  } ctlStrb_t;
endpackage

// File: rtl/mii_irq_ctl.sv
module mii_irq_ctl
  import mii_irq_pkg::*;
(
  input  logic             clk,
  input  logic             hostCmdDone,
  input  logic             intCmdDone,
  input  logic             pollMismatch,
  input  logic             phyDetect,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  input  logic             regRdEn,
  output ctlStrb_t         strb
);
  // Registered copy of the PHY level; it tracks the input in every cycle,
  // including reset cycles, so a steady level never looks like an edge.
  logic phyPrevQ;
  always_ff @(posedge clk) phyPrevQ <= phyDetect;

  logic [SRC_CNT-1:0] evRaw;
  always_comb begin
    evRaw           = '0;
    evRaw[SRC_HOST] = hostCmdDone;
    evRaw[SRC_INT]  = intCmdDone;
    evRaw[SRC_POLL] = pollMismatch;
    evRaw[SRC_PHY]  = phyDetect ^ phyPrevQ;
  end

  logic [SRC_CNT-1:0] oddBits, evenBits;
  for (genvar i = 0; i < SRC_CNT; i++) begin : g_split
    assign oddBits[i]  = regWrData[2*i+1];
    assign evenBits[i] = regWrData[2*i];
  end

  always_comb begin
    strb.setEv     = evRaw;
    strb.clrMask   = regWrEn ? oddBits : '0;
    strb.enLoad    = regWrEn;
    strb.enData    = evenBits;
    strb.rdCapture = regRdEn;
  end
endmodule

// File: rtl/mii_irq_dp.sv
module mii_irq_dp
  import mii_irq_pkg::*;
(
  input  logic             clk,
  input  logic             hardRstN,
  input  logic             softRst,
  input  logic             stopReq,
  input  ctlStrb_t         strb,
  output logic [REG_W-1:0] regRdData,
  output logic             irqOut
);
  logic [SRC_CNT-1:0] statusQ, statusNxt;
  logic [SRC_CNT-1:0] enableQ;
  logic [REG_W-1:0]   regView;
  logic               irqQ;
  logic [REG_W-1:0]   rdQ;

  // set has priority over clear so an event is never dropped
  always_comb begin
    for (int i = 0; i < SRC_CNT; i++) begin
      if (strb.setEv[i])        statusNxt[i] = 1'b1;
      else if (strb.clrMask[i]) statusNxt[i] = 1'b0;
      else                      statusNxt[i] = statusQ[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!hardRstN) begin
      statusQ <= '0;
      enableQ <= '0;
    end else begin
      statusQ <= statusNxt;
      if (strb.enLoad) enableQ <= strb.enData;
    end
  end

  for (genvar i = 0; i < SRC_CNT; i++) begin : g_view
    assign regView[2*i+1] = statusQ[i];
    assign regView[2*i]   = enableQ[i];
  end

  always_ff @(posedge clk) begin
    if (!hardRstN) begin
      irqQ <= 1'b0;
      rdQ  <= '0;
    end else begin
      irqQ <= |(statusQ & enableQ);
      if (strb.rdCapture) rdQ <= regView;
    end
  end

  assign irqOut    = irqQ;
  assign regRdData = rdQ;

  for (genvar i = 0; i < SRC_CNT; i++) begin : g_chk
    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (!hardRstN)
      strb.setEv[i] |=> statusQ[i]);
    // R5
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!hardRstN)
      (strb.clrMask[i] && !strb.setEv[i]) |=> !statusQ[i]);
  end

  // R10
  soft_hold_chk: assert property (@(posedge clk) disable iff (!hardRstN)
    ((softRst || stopReq) && strb.setEv == '0 && strb.clrMask == '0 && !strb.enLoad)
      |=> ($stable(statusQ) && $stable(enableQ)));

  // R8
  irq_idle_chk: assert property (@(posedge clk) disable iff (!hardRstN)
    ((statusQ & enableQ) == '0) |=> !irqOut);

  // R11
  rd_hold_chk: assert property (@(posedge clk) disable iff (!hardRstN)
    !strb.rdCapture |=> $stable(regRdData));
endmodule

// File: rtl/mii_irq_ctrl.sv
module mii_irq_ctrl
  import mii_irq_pkg::*;
(
  input  logic             clk,
  input  logic             hardRstN,
  input  logic             softRst,
  input  logic             stopReq,
  input  logic             hostCmdDone,
  input  logic             intCmdDone,
  input  logic             pollMismatch,
  input  logic             phyDetect,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  input  logic             regRdEn,
  output logic [REG_W-1:0] regRdData,
  output logic             irqOut
);
  ctlStrb_t strb;

  mii_irq_ctl u_ctl (
    .clk          (clk),
    .hostCmdDone  (hostCmdDone),
    .intCmdDone   (intCmdDone),
    .pollMismatch (pollMismatch),
    .phyDetect    (phyDetect),
    .regWrEn      (regWrEn),
    .regWrData    (regWrData),
    .regRdEn      (regRdEn),
    .strb         (strb)
  );

  mii_irq_dp u_dp (
    .clk       (clk),
    .hardRstN  (hardRstN),
    .softRst   (softRst),
    .stopReq   (stopReq),
    .strb      (strb),
    .regRdData (regRdData),
    .irqOut    (irqOut)
  );
endmodule

// File: tb/tb_mii_irq_ctrl.sv
`timescale 1ns/1ps
module tb_mii_irq_ctrl;
  logic clk = 1'b0;
  logic hardRstN = 1'b0, softRst = 1'b0, stopReq = 1'b0;
  logic hostCmdDone = 1'b0, intCmdDone = 1'b0, pollMismatch = 1'b0, phyDetect = 1'b0;
  logic regWrEn = 1'b0, regRdEn = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic irqOut;

  always #2.5 clk = ~clk;

  mii_irq_ctrl dut (.*);

  int vecs = 0, fails = 0;
  logic [3:0] stM = '0, enM = '0;
  logic irqM = 1'b0, phyM = 1'b0;
  logic [7:0] rdM = '0;

  function automatic logic [7:0] packReg(logic [3:0] st, logic [3:0] en);
    logic [7:0] r;
    for (int i = 0; i < 4; i++) begin
      r[2*i+1] = st[i];
      r[2*i]   = en[i];
    end
    return r;
  endfunction

  function automatic logic [3:0] oddOf(logic [7:0] d);
    logic [3:0] r;
    for (int i = 0; i < 4; i++) r[i] = d[2*i+1];
    return r;
  endfunction

  function automatic logic [3:0] evenOf(logic [7:0] d);
    logic [3:0] r;
    for (int i = 0; i < 4; i++) r[i] = d[2*i];
    return r;
  endfunction

  task automatic check(input string tag);
    vecs++;
    if (irqOut !== irqM || regRdData !== rdM) begin
      fails++;
      $display("FAIL %s: irqOut=%b exp %b, regRdData=%h exp %h", tag, irqOut, irqM, regRdData, rdM);
    end
  endtask

  // drive inputs (called just after a falling edge), clock once, update model
  task automatic step(input logic rst, input logic [3:0] ev, input logic phy,
                      input logic we, input logic [7:0] wd, input logic re,
                      input logic sr, input logic sp);
    logic [3:0] setV;
    hardRstN = ~rst; hostCmdDone = ev[0]; intCmdDone = ev[1]; pollMismatch = ev[2];
    phyDetect = phy; regWrEn = we; regWrData = wd; regRdEn = re; softRst = sr; stopReq = sp;
    @(posedge clk);
    if (rst) begin
      stM = '0; enM = '0; irqM = 1'b0; rdM = '0;
    end else begin
      irqM = |(stM & enM);
      if (re) rdM = packReg(stM, enM);
      setV = {phy ^ phyM, ev[2:0]};
      stM = (stM & ~(we ? oddOf(wd) : 4'b0)) | setV;
      if (we) enM = evenOf(wd);
    end
    phyM = phy;
    @(negedge clk);
  endtask

  task automatic idle(input logic re);
    step(1'b0, 4'b0, phyDetect, 1'b0, 8'h00, re, 1'b0, 1'b0);
  endtask

  task automatic wr(input logic [7:0] d);
    step(1'b0, 4'b0, phyDetect, 1'b1, d, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic ev(input logic [3:0] e);
    step(1'b0, e, phyDetect, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    @(negedge clk);
    // R9 reset state
    step(1'b1, 4'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
    step(1'b1, 4'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
    check("R9 reset");
    idle(1'b1); check("R9 read after reset");

    // R1 host completion
    ev(4'b0001); idle(1'b1); check("R1 host flag bit1");
    // R8 enable host -> irq one cycle later
    wr(8'h01); check("R6 enable write");
    idle(1'b0); check("R8 irq rises");
    // R2 internal completion leaves host bit alone
    wr(8'h02); idle(1'b1); check("R5 host cleared");
    ev(4'b0010); idle(1'b1); check("R2 internal flag bit3");
    // R3 poll mismatch without its enable: no irq
    wr(8'h0A); ev(4'b0100); idle(1'b0); idle(1'b1); check("R3 mismatch no enable");
    wr(8'h10); idle(1'b0); check("R3 mismatch enabled irq");
    // R5 writing zeros leaves status
    wr(8'h00); idle(1'b1); check("R5 zero write keeps status");
    wr(8'hAA); idle(1'b1); check("R5 clear all");
    // R4 rising and falling phy edges
    step(1'b0, 4'b0, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
    idle(1'b1); check("R4 rising edge");
    wr(8'h80); idle(1'b1); check("R4 cleared");
    step(1'b0, 4'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
    idle(1'b1); check("R4 falling edge");
    // R7 set and clear collide
    wr(8'hAA);
    step(1'b0, 4'b0001, 1'b0, 1'b1, 8'h02, 1'b0, 1'b0, 1'b0);
    idle(1'b1); check("R7 set beats clear");
    // R10 soft reset and stop hold flags
    wr(8'h55); ev(4'b0110);
    step(1'b0, 4'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0);
    step(1'b0, 4'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
    step(1'b0, 4'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1);
    check("R10 soft reset and stop");
    // R11 read data holds without strobe
    ev(4'b1000 & 4'b0000); wr(8'h00); idle(1'b0); idle(1'b0); check("R11 read hold");
    // R4 level held high through reset: no false edge
    step(1'b1, 4'b0, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
    step(1'b1, 4'b0, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
    check("R9 reset mid run");
    idle(1'b0); idle(1'b1); check("R4 no edge after reset");

    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic [3:0] e;
      logic ph, we, re, sr, sp;
      logic [7:0] wd;
      e  = 4'($urandom_range(0, 15)) & {1'b0, ($urandom_range(0, 3) == 0) ? 3'b111 : 3'b000};
      ph = ($urandom_range(0, 7) == 0) ? ~phyDetect : phyDetect;
      we = ($urandom_range(0, 4) == 0);
      wd = 8'($urandom);
      re = $urandom_range(0, 1) == 1;
      sr = ($urandom_range(0, 9) == 0);
      sp = ($urandom_range(0, 9) == 0);
      step(($urandom_range(0, 499) == 0), e, ph, we, wd, re, sr, sp);
      check("R8/R11 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule